// File: doc/BRIEF.md
# Posted Write Buffer

This block is a one-entry store buffer that sits between a processor's store port and the write port of an external memory. The processor hands over a store in a single cycle. The buffer then presents the address, data and byte enables to memory under a valid/ready handshake and holds them until memory takes them. The processor stalls only when it stores while the entry is still taken, or while too many accepted writes still await their completion response.

A 32-bit status word reports two separate conditions. The empty flag shows whether the buffer slot is free. The finished flag shows whether every buffered write has actually been committed, which memory signals with a completion pulse. This pulse may come many cycles after the handshake. With the two flags, software can tell a store that has only been posted apart from one that is durable.

Top module: `posted_wbuf`

## Requirements
- R1: After reset, `stat_o` reads 0x0000_0300, `cpu_rdy_o` is 1 and `mem_vld_o` is 0.
- R2: A store is accepted on a rising edge where `cpu_req_i` and `cpu_rdy_o` are both 1. From the next cycle, `mem_vld_o` is 1 and carries the captured address, data and byte enables. In that same cycle, status bit 8 (empty) and bit 9 (finished) both read 0.
- R3: While `mem_vld_o` is 1 and `mem_rdy_i` is 0, `mem_vld_o`, `mem_addr_o`, `mem_data_o` and `mem_be_o` hold their values into the next cycle.
- R4: After an edge where `mem_vld_o` and `mem_rdy_i` are both 1, `mem_vld_o` is 0 and status bit 8 reads 1, unless a new store is accepted.
- R5: Status bit 9 reads 1 only when the slot is empty and a `mem_done_i` pulse has arrived for every write that memory accepted. It rises in the cycle after the last such pulse.
- R6: `cpu_rdy_o` is 0 while the slot is occupied. A store offered while `cpu_rdy_o` is 0 is ignored, and the buffered payload is unchanged.
- R7: `cpu_rdy_o` is 0 while the number of writes accepted by memory but not yet completed equals `MAX_OUT` (default 2).
- R8: Status bits 31 to 10 and 7 to 0 always read 0.
- R9: If a store is accepted on the same edge as the last outstanding `mem_done_i`, status bit 9 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Store request |
| cpu_addr_i | input | ADDR_W | Store address |
| cpu_data_i | input | DATA_W | Store data |
| cpu_be_i | input | DATA_W/8 | Store byte enables |
| cpu_rdy_o | output | 1 | Store can be accepted |
| mem_vld_o | output | 1 | Buffered write valid |
| mem_addr_o | output | ADDR_W | Buffered address |
| mem_data_o | output | DATA_W | Buffered data |
| mem_be_o | output | DATA_W/8 | Buffered byte enables |
| mem_rdy_i | input | 1 | Memory accepts the write |
| mem_done_i | input | 1 | Memory completion pulse, one per accepted write |
| stat_o | output | 32 | Status word: bit 9 finished, bit 8 empty |

## Verification
Every result is due exactly one cycle after the edge that causes it. A store's payload, `mem_vld_o` and both status bits follow the accept edge by one cycle. The empty flag and `cpu_rdy_o` follow the memory handshake edge by one cycle, and the finished flag follows the final completion pulse by one cycle. The bench drives inputs on the falling edge and advances its own reference model on the rising edge. It compares all outputs on the following falling edge, so every check lands in the cycle the result is due. Directed cases cover the stall on a full slot, the outstanding-response limit and a store that coincides with the final completion pulse.

// File: rtl/posted_wbuf_pkg.sv
package posted_wbuf_pkg;
  localparam int STAT_W    = 32;
  localparam int FIN_BIT   = 9;
  localparam int EMPTY_BIT = 8;

  function automatic logic [STAT_W-1:0] pack_status(logic fin, logic empty);
    logic [STAT_W-1:0] w;
    w            = '0;
    w[FIN_BIT]   = fin;
    w[EMPTY_BIT] = empty;
    return w;
  endfunction
endpackage

// File: rtl/posted_wbuf_slot.sv
module posted_wbuf_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              mem_rdy_i,
  output logic              full_o,
  output logic              issue_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);
  logic              full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;

  assign issue_o = full_q && mem_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      full_q <= 1'b0;
    else if (load_i)  full_q <= 1'b1;
    else if (issue_o) full_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      be_q   <= be_i;
    end
  end

  assign full_o = full_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign be_o   = be_q;

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !mem_rdy_i |=> full_q && $stable(addr_q) && $stable(data_q) && $stable(be_q));

  assert_no_load_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && full_q));
endmodule

// File: rtl/posted_wbuf_track.sv
module posted_wbuf_track #(
  parameter int MAX_OUT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  output logic idle_o,
  output logic room_o
);
  localparam int CW = $clog2(MAX_OUT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({issue_i, done_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign idle_o = (cnt_q == '0);
  assign room_o = (cnt_q < CW'(MAX_OUT));

  assert_done_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> cnt_q != '0);

  assert_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_OUT));
endmodule

// File: rtl/posted_wbuf_status.sv
module posted_wbuf_status
  import posted_wbuf_pkg::*;
(
  input  logic              full_i,
  input  logic              idle_i,
  output logic [STAT_W-1:0] stat_o
);
  assign stat_o = pack_status(!full_i && idle_i, !full_i);
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf
  import posted_wbuf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 2,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  output logic              cpu_rdy_o,
  output logic              mem_vld_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [BE_W-1:0]   mem_be_o,
  input  logic              mem_rdy_i,
  input  logic              mem_done_i,
  output logic [31:0]       stat_o
);
  logic full, issue, idle, room, load;

  assign cpu_rdy_o = !full && room;
  assign load      = cpu_req_i && cpu_rdy_o;
  assign mem_vld_o = full;

  posted_wbuf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_slot (
    .clk_i, .rst_ni,
    .load_i   (load),
    .addr_i   (cpu_addr_i),
    .data_i   (cpu_data_i),
    .be_i     (cpu_be_i),
    .mem_rdy_i,
    .full_o   (full),
    .issue_o  (issue),
    .addr_o   (mem_addr_o),
    .data_o   (mem_data_o),
    .be_o     (mem_be_o)
  );

  posted_wbuf_track #(.MAX_OUT(MAX_OUT)) u_track (
    .clk_i, .rst_ni,
    .issue_i (issue),
    .done_i  (mem_done_i),
    .idle_o  (idle),
    .room_o  (room)
  );

  posted_wbuf_status u_status (
    .full_i (full),
    .idle_i (idle),
    .stat_o (stat_o)
  );

  assert_accept_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_rdy_o |=> mem_vld_o && !stat_o[EMPTY_BIT] && !stat_o[FIN_BIT]);

  assert_drain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vld_o && mem_rdy_i |=> !mem_vld_o && stat_o[EMPTY_BIT]);

  assert_fin_needs_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[FIN_BIT] |-> stat_o[EMPTY_BIT] && !mem_vld_o);

  assert_stall_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_vld_o |-> !cpu_rdy_o);

  assert_fin_late_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_rdy_o && mem_done_i |=> !stat_o[FIN_BIT]);
endmodule

// File: tb/posted_wbuf_tb.sv
module posted_wbuf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int MAXO = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, mrdy = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [BW-1:0] be = '0;
  logic          cpu_rdy, mem_vld;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BW-1:0] mem_be;
  logic [31:0]   stat;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic          m_full = 1'b0;
  int            m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic [BW-1:0] m_be = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posted_wbuf #(.ADDR_W(AW), .DATA_W(DW), .MAX_OUT(MAXO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_addr_i(addr), .cpu_data_i(data), .cpu_be_i(be),
    .cpu_rdy_o(cpu_rdy),
    .mem_vld_o(mem_vld), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_be_o(mem_be),
    .mem_rdy_i(mrdy), .mem_done_i(done),
    .stat_o(stat)
  );

  function automatic logic exp_rdy();
    return !m_full && (m_cnt < MAXO);
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] w = '0;
    w[9] = !m_full && (m_cnt == 0);
    w[8] = !m_full;
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R6/R7 cpu_rdy_o", 64'(cpu_rdy), 64'(exp_rdy()));
    chk("R2/R4 mem_vld_o", 64'(mem_vld), 64'(m_full));
    chk("R5/R8 stat_o", 64'(stat), 64'(exp_stat()));
    if (m_full) begin
      chk("R2/R3 mem_addr_o", 64'(mem_addr), 64'(m_addr));
      chk("R2/R3 mem_data_o", 64'(mem_data), 64'(m_data));
      chk("R2/R3 mem_be_o", 64'(mem_be), 64'(m_be));
    end
  endtask

  // drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(logic r, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] b,
                      logic mr, logic dn);
    logic acc, hs;
    req = r; addr = a; data = d; be = b; mrdy = mr; done = dn;
    acc = r && exp_rdy();
    hs  = m_full && mr;
    @(posedge clk);
    if (acc) begin
      m_full = 1'b1; m_addr = a; m_data = d; m_be = b;
    end else if (hs) begin
      m_full = 1'b0;
    end
    m_cnt = m_cnt + (hs ? 1 : 0) - (dn ? 1 : 0);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h1d5e_ed01);
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 stat_o", 64'(stat), 64'h300);
    chk("R1 cpu_rdy_o", 64'(cpu_rdy), 64'd1);
    chk("R1 mem_vld_o", 64'(mem_vld), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R6: store, hold while memory stalls, ignored second store
    step(1, 32'hA000_0010, 32'h1111_2222, 4'hF, 0, 0);
    chk("R2 empty bit clear", 64'(stat[8]), 64'd0);
    chk("R2 finished bit clear", 64'(stat[9]), 64'd0);
    step(1, 32'hBBBB_0000, 32'hDEAD_BEEF, 4'h3, 0, 0);
    chk("R6 ignored store addr", 64'(mem_addr), 64'hA000_0010);
    chk("R6 ignored store data", 64'(mem_data), 64'h1111_2222);
    step(0, '0, '0, '0, 0, 0);
    chk("R3 held be", 64'(mem_be), 64'hF);
    // R4: handshake drains slot; finished stays low until completion
    step(0, '0, '0, '0, 1, 0);
    chk("R4 empty after handshake", 64'(stat[8]), 64'd1);
    chk("R5 finished waits for done", 64'(stat[9]), 64'd0);
    step(0, '0, '0, '0, 0, 1);
    chk("R5 finished after done", 64'(stat[9]), 64'd1);

    // R7: two uncompleted writes block new stores
    step(1, 32'h10, 32'h1, 4'h1, 1, 0);
    step(0, '0, '0, '0, 1, 0);
    step(1, 32'h20, 32'h2, 4'h2, 1, 0);
    step(0, '0, '0, '0, 1, 0);
    chk("R7 rdy low at limit", 64'(cpu_rdy), 64'd0);
    step(1, 32'h30, 32'h3, 4'h4, 0, 0);
    chk("R7 store refused at limit", 64'(mem_vld), 64'd0);
    step(0, '0, '0, '0, 0, 1);
    chk("R7 rdy back after done", 64'(cpu_rdy), 64'd1);
    // R9: store on the edge of the last completion
    step(1, 32'h40, 32'h4, 4'h8, 0, 1);
    chk("R9 finished stays low", 64'(stat[9]), 64'd0);
    step(0, '0, '0, '0, 1, 0);
    step(0, '0, '0, '0, 0, 1);
    chk("R5 finished after R9 drain", 64'(stat[9]), 64'd1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic r, mr, dn;
      r  = ($urandom % 3) != 0;
      mr = ($urandom % 3) != 0;
      dn = (m_cnt > 0) && (($urandom % 2) == 1);
      step(r, $urandom, $urandom, BW'($urandom), mr, dn);
      chk("R8 reserved bits", 64'(stat & 32'hFFFF_FCFF), 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule